// File: doc/BRIEF.md
# Lockable Secure Key Register

This block keeps a 256-bit secret for a cryptographic engine. Boot firmware copies the secret from non-volatile storage into the block, one 32-bit word per write, over a simple memory-mapped slave port. While the secret is unlocked, firmware can read the words back to verify them. Firmware then sets a sticky lock. From that point the secret cannot be read or changed through the slave port or through a second debug access port. Both ports follow the same rules.

The whole key is always driven on a private parallel output to the crypto engine. Both access ports use the same single-cycle handshake. A request is held valid for one cycle. The response appears one cycle later as a done pulse with read data and an error flag. The error flag marks an access that was refused.

A synchronous reset clears the lock and every key word on the same clock edge. No state exists after reset in which the old secret is present while the lock is open.

Top module: `keyvault_top`

## Requirements
- R1: Before the lock is set, a write to byte offset 4*i (i from 0 to 7) on either port stores the data as key word i. A read of that offset returns the stored word. The error flag stays 0 for both.
- R2: While locked, a slave-port read of any key offset (0x00 to 0x1C) returns zero and raises the error flag.
- R3: While locked, a slave-port write to a key offset leaves the key unchanged and raises the error flag.
- R4: The debug port obeys the same lock. While locked, debug reads of key offsets return zero, debug writes to them are dropped, and both raise the error flag.
- R5: Reset clears the lock and all eight key words on the same clock edge. After reset, `key_out` is zero and `locked` is 0.
- R6: Offset 0x20 holds the lock control. A write with bit 0 set sets the lock. A write with bit 0 clear is ignored. Only reset clears the lock. A read returns the lock state in bit 0 and zeros above it. Accesses to 0x20 never raise the error flag.
- R7: `key_out` carries key word i in bits [32*i+31 : 32*i] at all times, whatever the lock state.
- R8: Every request gets `done` high for exactly the following cycle. Read data is zero for writes.
- R9: Offsets at or above 0x24 read as zero, ignore writes and raise the error flag. Address bits [1:0] are ignored for every offset.
- R10: If both ports write the same key word in the same cycle while unlocked, the slave-port data is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Slave-port request strobe |
| bus_write | input | 1 | Slave-port write (1) or read (0) |
| bus_addr | input | 8 | Slave-port byte offset |
| bus_wdata | input | 32 | Slave-port write data |
| bus_done | output | 1 | Slave-port response strobe |
| bus_rdata | output | 32 | Slave-port read data |
| bus_err | output | 1 | Slave-port access refused |
| dbg_valid | input | 1 | Debug-port request strobe |
| dbg_write | input | 1 | Debug-port write (1) or read (0) |
| dbg_addr | input | 8 | Debug-port byte offset |
| dbg_wdata | input | 32 | Debug-port write data |
| dbg_done | output | 1 | Debug-port response strobe |
| dbg_rdata | output | 32 | Debug-port read data |
| dbg_err | output | 1 | Debug-port access refused |
| key_out | output | 256 | Full key to the crypto engine |
| locked | output | 1 | Current lock state |

## Verification
Directed sequences load a known key and read it back on both ports. They then try clearing the lock with a zero write, set it, and attack every key offset from both ports. This separates a lock that only gates one port, or only reads, from one that guards both ports and both directions. A reset after locking shows whether the lock and the key are wiped together. Randomized phases mix reads, writes, misaligned and unmapped offsets, and late lock writes across both ports. They catch decode and gating errors that depend on the order of accesses. A same-cycle write from both ports to one word checks which port wins.

// File: rtl/kv_pkg.sv
package kv_pkg;

  typedef enum logic [1:0] {
    ACC_KEY  = 2'd0,
    ACC_CTRL = 2'd1,
    ACC_NONE = 2'd2
  } acc_class_e;

endpackage

// File: rtl/kv_lock.sv
module kv_lock (
  input  logic clk,
  input  logic rst,
  input  logic set_a,
  input  logic set_b,
  output logic locked
);

  always_ff @(posedge clk) begin
    if (rst)                 locked <= 1'b0;
    else if (set_a || set_b) locked <= 1'b1;
  end

  AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (rst)
    locked |=> locked); // R6

endmodule

// File: rtl/kv_store.sv
module kv_store #(
  parameter int DATA_W    = 32,
  parameter int KEY_WORDS = 8,
  localparam int IDX_W    = $clog2(KEY_WORDS),
  localparam int KEY_W    = DATA_W * KEY_WORDS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              locked,
  input  logic              a_we,
  input  logic [IDX_W-1:0]  a_idx,
  input  logic [DATA_W-1:0] a_data,
  input  logic              b_we,
  input  logic [IDX_W-1:0]  b_idx,
  input  logic [DATA_W-1:0] b_data,
  output logic [KEY_W-1:0]  key_flat
);

  for (genvar i = 0; i < KEY_WORDS; i++) begin : g_word
    logic [DATA_W-1:0] word_q;
    always_ff @(posedge clk) begin
      if (rst)                                   word_q <= '0;
      else if (a_we && a_idx == IDX_W'(i))       word_q <= a_data;
      else if (b_we && b_idx == IDX_W'(i))       word_q <= b_data;
    end
    assign key_flat[i*DATA_W +: DATA_W] = word_q;
  end

  AST_KEY_FROZEN: assert property (@(posedge clk) disable iff (rst)
    locked |=> $stable(key_flat)); // R3

endmodule

// File: rtl/kv_port.sv
module kv_port
  import kv_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 32,
  parameter int KEY_WORDS = 8,
  localparam int IDX_W    = $clog2(KEY_WORDS),
  localparam int WIDX_W   = ADDR_W - 2,
  localparam int KEY_W    = DATA_W * KEY_WORDS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              locked,
  input  logic [KEY_W-1:0]  key_flat,
  output logic              key_we,
  output logic [IDX_W-1:0]  key_idx,
  output logic [DATA_W-1:0] key_wdata,
  output logic              lock_set,
  output logic              rsp_done,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              rsp_err
);

  localparam logic [WIDX_W-1:0] CTRL_IDX = WIDX_W'(KEY_WORDS);

  logic [WIDX_W-1:0] widx;
  logic              unused_lo;
  acc_class_e        acc;
  logic              refused;
  logic [DATA_W-1:0] rd_val;

  assign widx      = req_addr[ADDR_W-1:2];
  assign unused_lo = ^req_addr[1:0];
  assign key_idx   = widx[IDX_W-1:0];
  assign key_wdata = req_wdata;

  always_comb begin
    if (widx < CTRL_IDX)       acc = ACC_KEY;
    else if (widx == CTRL_IDX) acc = ACC_CTRL;
    else                       acc = ACC_NONE;
  end

  assign refused  = (acc == ACC_NONE) || (acc == ACC_KEY && locked);
  assign key_we   = req_valid && req_write && acc == ACC_KEY && !locked;
  assign lock_set = req_valid && req_write && acc == ACC_CTRL && req_wdata[0];

  always_comb begin
    rd_val = '0;
    case (acc)
      ACC_KEY:  if (!locked) rd_val = key_flat[key_idx*DATA_W +: DATA_W];
      ACC_CTRL: rd_val = {{(DATA_W-1){1'b0}}, locked};
      default:  rd_val = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_done  <= 1'b0;
      rsp_rdata <= '0;
      rsp_err   <= 1'b0;
    end else begin
      rsp_done  <= req_valid;
      rsp_rdata <= (req_valid && !req_write) ? rd_val : '0;
      rsp_err   <= req_valid && refused;
    end
  end

  AST_LOCKED_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_write && acc == ACC_KEY && locked) |=> (rsp_err && rsp_rdata == '0)); // R2
  AST_DONE_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_done); // R8
  AST_NO_SPURIOUS_DONE: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !rsp_done); // R8
  AST_UNMAPPED_ERR: assert property (@(posedge clk) disable iff (rst)
    (req_valid && widx > CTRL_IDX) |=> (rsp_err && rsp_rdata == '0)); // R9

endmodule

// File: rtl/keyvault_top.sv
module keyvault_top #(
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 32,
  parameter int KEY_WORDS = 8,
  localparam int IDX_W    = $clog2(KEY_WORDS),
  localparam int KEY_W    = DATA_W * KEY_WORDS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic              bus_done,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_err,
  input  logic              dbg_valid,
  input  logic              dbg_write,
  input  logic [ADDR_W-1:0] dbg_addr,
  input  logic [DATA_W-1:0] dbg_wdata,
  output logic              dbg_done,
  output logic [DATA_W-1:0] dbg_rdata,
  output logic              dbg_err,
  output logic [KEY_W-1:0]  key_out,
  output logic              locked
);

  logic              bus_we, dbg_we, bus_lset, dbg_lset;
  logic [IDX_W-1:0]  bus_idx, dbg_idx;
  logic [DATA_W-1:0] bus_kd, dbg_kd;

  kv_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .KEY_WORDS(KEY_WORDS)) u_bus_port (
    .clk(clk), .rst(rst),
    .req_valid(bus_valid), .req_write(bus_write), .req_addr(bus_addr), .req_wdata(bus_wdata),
    .locked(locked), .key_flat(key_out),
    .key_we(bus_we), .key_idx(bus_idx), .key_wdata(bus_kd), .lock_set(bus_lset),
    .rsp_done(bus_done), .rsp_rdata(bus_rdata), .rsp_err(bus_err)
  );

  kv_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .KEY_WORDS(KEY_WORDS)) u_dbg_port (
    .clk(clk), .rst(rst),
    .req_valid(dbg_valid), .req_write(dbg_write), .req_addr(dbg_addr), .req_wdata(dbg_wdata),
    .locked(locked), .key_flat(key_out),
    .key_we(dbg_we), .key_idx(dbg_idx), .key_wdata(dbg_kd), .lock_set(dbg_lset),
    .rsp_done(dbg_done), .rsp_rdata(dbg_rdata), .rsp_err(dbg_err)
  );

  kv_lock u_lock (
    .clk(clk), .rst(rst), .set_a(bus_lset), .set_b(dbg_lset), .locked(locked)
  );

  kv_store #(.DATA_W(DATA_W), .KEY_WORDS(KEY_WORDS)) u_store (
    .clk(clk), .rst(rst), .locked(locked),
    .a_we(bus_we), .a_idx(bus_idx), .a_data(bus_kd),
    .b_we(dbg_we), .b_idx(dbg_idx), .b_data(dbg_kd),
    .key_flat(key_out)
  );

  AST_RESET_WIPES: assert property (@(posedge clk)
    rst |=> (key_out == '0 && !locked)); // R5
  AST_DBG_LOCKED_REFUSED: assert property (@(posedge clk) disable iff (rst)
    (dbg_valid && locked && dbg_addr[ADDR_W-1:2] < (ADDR_W-2)'(KEY_WORDS)) |=> (dbg_err && dbg_rdata == '0)); // R4

endmodule

// File: tb/test_keyvault_top.sv
`timescale 1ns/1ps
module test_keyvault_top;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         bus_valid = 1'b0, bus_write = 1'b0;
  logic [7:0]   bus_addr = '0;
  logic [31:0]  bus_wdata = '0;
  logic         dbg_valid = 1'b0, dbg_write = 1'b0;
  logic [7:0]   dbg_addr = '0;
  logic [31:0]  dbg_wdata = '0;
  logic         bus_done, bus_err, dbg_done, dbg_err, locked;
  logic [31:0]  bus_rdata, dbg_rdata;
  logic [255:0] key_out;

  int n_chk = 0;
  int n_bad = 0;
  logic [31:0] mk [8];
  bit ml;

  always #2.5 clk = ~clk;

  keyvault_top i_keyvault_top (
    .clk(clk), .rst(rst),
    .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_done(bus_done), .bus_rdata(bus_rdata), .bus_err(bus_err),
    .dbg_valid(dbg_valid), .dbg_write(dbg_write), .dbg_addr(dbg_addr), .dbg_wdata(dbg_wdata),
    .dbg_done(dbg_done), .dbg_rdata(dbg_rdata), .dbg_err(dbg_err),
    .key_out(key_out), .locked(locked)
  );

  function automatic logic [255:0] model_key();
    logic [255:0] k;
    for (int i = 0; i < 8; i++) k[i*32 +: 32] = mk[i];
    return k;
  endfunction

  function automatic string tag_of(bit dbg, bit wr, logic [7:0] a);
    if (a[7:2] < 6'd8) begin
      if (!ml) return "R1";
      if (dbg) return "R4";
      return wr ? "R3" : "R2";
    end
    if (a[7:2] == 6'd8) return "R6";
    return "R9";
  endfunction

  task automatic chk(string req, logic [255:0] got, logic [255:0] exp, string what);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  task automatic access(bit dbg, bit wr, logic [7:0] a, logic [31:0] wd);
    logic [31:0] e_rd;
    bit e_err;
    string t;
    t = tag_of(dbg, wr, a);
    e_rd = '0; e_err = 1'b0;
    if (a[7:2] < 6'd8) begin
      if (ml) e_err = 1'b1;
      else if (wr) mk[a[4:2]] = wd;
      else e_rd = mk[a[4:2]];
    end else if (a[7:2] == 6'd8) begin
      if (!wr) e_rd = {31'd0, ml};
      else if (wd[0]) ml = 1'b1;
    end else e_err = 1'b1;
    @(negedge clk);
    if (dbg) begin dbg_valid = 1; dbg_write = wr; dbg_addr = a; dbg_wdata = wd; end
    else     begin bus_valid = 1; bus_write = wr; bus_addr = a; bus_wdata = wd; end
    @(negedge clk);
    dbg_valid = 0; bus_valid = 0;
    if (dbg) begin
      chk("R8", 256'(dbg_done), 256'(1), "dbg done");
      chk(t, 256'(dbg_rdata), 256'(e_rd), "dbg rdata");
      chk(t, 256'(dbg_err), 256'(e_err), "dbg err");
    end else begin
      chk("R8", 256'(bus_done), 256'(1), "bus done");
      chk(t, 256'(bus_rdata), 256'(e_rd), "bus rdata");
      chk(t, 256'(bus_err), 256'(e_err), "bus err");
    end
    chk("R7", key_out, model_key(), "key_out");
    chk("R6", 256'(locked), 256'(ml), "locked");
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1;
    @(negedge clk); rst = 0;
    for (int i = 0; i < 8; i++) mk[i] = '0;
    ml = 0;
    chk("R5", key_out, '0, "key after reset");
    chk("R5", 256'(locked), 256'(0), "lock after reset");
    chk("R8", 256'({bus_done, dbg_done}), 256'(0), "done idle after reset");
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(5.0 * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (2) @(negedge clk);
    do_reset();
    // R1: load and read back on both ports
    for (int i = 0; i < 8; i++) access(0, 1, 8'(4*i), 32'hA5000000 + 32'(i * 32'h1111));
    for (int i = 0; i < 8; i++) access(i[0], 0, 8'(4*i), '0);
    // R10: both ports write word 3 together
    @(negedge clk);
    bus_valid = 1; bus_write = 1; bus_addr = 8'h0C; bus_wdata = 32'hB0B0B0B0;
    dbg_valid = 1; dbg_write = 1; dbg_addr = 8'h0C; dbg_wdata = 32'hDEADDEAD;
    mk[3] = 32'hB0B0B0B0;
    @(negedge clk);
    bus_valid = 0; dbg_valid = 0;
    chk("R10", 256'(key_out[3*32 +: 32]), 256'(32'hB0B0B0B0), "bus wins");
    // R6: zero write ignored, then lock
    access(0, 1, 8'h20, 32'hFFFFFFFE);
    access(1, 0, 8'h20, '0);
    access(0, 1, 8'h20, 32'h1);
    access(0, 1, 8'h20, 32'h0);
    // R2 R3 R4: attack all key words from both ports
    for (int i = 0; i < 8; i++) begin
      access(0, 0, 8'(4*i), '0);
      access(0, 1, 8'(4*i + 1), 32'h12345678);
      access(1, 0, 8'(4*i + 3), '0);
      access(1, 1, 8'(4*i), 32'h87654321);
    end
    access(0, 1, 8'h24, 32'h1);
    access(1, 0, 8'hFC, '0);
    // R5: reset after lock wipes key together with lock
    do_reset();
    // random phases
    for (int r = 0; r < 3; r++) begin
      for (int n = 0; n < 150; n++) begin
        bit dbg, wr;
        logic [7:0] a;
        dbg = $urandom_range(0, 3) == 0;
        wr  = $urandom_range(0, 1) == 1;
        a   = 8'($urandom_range(0, 47));
        if (a[7:2] == 6'd8 && wr && n < 60) a = 8'h00;
        access(dbg, wr, a, $urandom);
      end
      do_reset();
    end
    finish_run();
  end

endmodule